// File: doc/BRIEF.md
# Dual-Delay Programmable Pulse Generator

This block turns every rising edge of a trigger input into one output pulse whose leading edge and width are both programmable. The edge starts two delay channels at once. The first channel sets an RS latch after a programmed number of cycles. The second channel clears the latch after its own programmed number of cycles. The pulse width is therefore the difference between the two delays.

Two 8-bit codes are written through a small staging interface with a single load strobe. The staged pair moves into the channels as a unit, and only at the next trigger edge. Software or a sequencer can therefore change the codes in every trigger period and produce a pseudorandom train of pulses. A pair in which the clear code is not larger than the set code does not produce a pulse. In that case an error indication is raised for the period.

Top module: `dual_delay_pulse_gen`

## Requirements
- R1: After reset, pulse_o and err_o are both 0.
- R2: A period starts at the first clock edge at which trig_i is sampled 1 after having been sampled 0. Holding trig_i high for further cycles does not start another period.
- R3: With set code S taken at the start edge, pulse_o becomes 1 after the edge S+2 cycles after the start edge. The start edge counts as edge 0.
- R4: With clear code C > S, pulse_o returns to 0 after the edge C+2 cycles after the start edge, giving a width of C-S cycles.
- R5: Each period with C > S gives exactly one pulse, so the pulse rate equals the trigger rate.
- R6: When C <= S, pulse_o stays 0 for the period. err_o is 1 from the start edge until the next start edge. For a valid pair, err_o is 0 over the same interval.
- R7: A pulse of load_i copies set_code_i and clr_code_i into staging. A load made while a period is running does not alter that period's pulse. The staged pair is used at the next start, whether or not load_i is pulsed again.
- R8: Back-to-back periods may use a different code pair each, and each pulse follows its own pair.
- R9: Set code 0 gives a leading edge 2 cycles after the start edge. A set code of 250 with a clear code of 255 gives the edges at 252 and 257.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger; rising edge starts a period |
| load_i | input | 1 | Stage strobe for both codes |
| set_code_i | input | 8 | Leading-edge delay code |
| clr_code_i | input | 8 | Trailing-edge delay code |
| pulse_o | output | 1 | Generated pulse |
| err_o | output | 1 | Invalid code pair in current period |

## Verification
The hardest case to reach is a load that arrives while a period is still counting. That load must stay out of the running pulse and still take effect at the following edge without a second load. The bench stages one pair, fires a trigger, and loads a different pair a few cycles into the delay. It then measures both edges of the current pulse and of the next one. A trigger held high for several cycles, and pairs with equal or inverted codes, are driven in the same way. These cover re-arming and the error path.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_SET = 0;
  localparam int unsigned CH_CLR = 1;
  localparam int unsigned FIRE_LAT = 2;
endpackage

// File: rtl/pg_edge_detect.sv
module pg_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b1;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  assert_one_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pg_delay_chan.sv
module pg_delay_chan #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              busy_q;
  logic              fire_q;
  logic              hit;

  assign hit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= hit && !start_i;
      if (start_i) begin
        cnt_q  <= code_i;
        busy_q <= 1'b1;
      end else if (hit) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign fire_o = fire_q;
  assign busy_o = busy_q;

  assert_fire_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  assert_start_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
endmodule

// File: rtl/pg_rs_latch.sv
module pg_rs_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // clear wins when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (clr_i) q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dual_delay_pulse_gen.sv
module dual_delay_pulse_gen #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] set_code_i,
  input  logic [CODE_W-1:0] clr_code_i,
  output logic              pulse_o,
  output logic              err_o
);
  import pg_pkg::*;

  logic [CODE_W-1:0] stage_q [NUM_CH];
  logic [NUM_CH-1:0] fire;
  logic [NUM_CH-1:0] busy;
  logic              start;
  logic              err_q;

  pg_edge_detect i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (trig_i),
    .rise_o (start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q[CH_SET] <= '0;
      stage_q[CH_CLR] <= '0;
    end else if (load_i) begin
      stage_q[CH_SET] <= set_code_i;
      stage_q[CH_CLR] <= clr_code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (start) err_q <= (stage_q[CH_CLR] <= stage_q[CH_SET]);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pg_delay_chan #(.CODE_W(CODE_W)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .code_i  (stage_q[g]),
      .fire_o  (fire[g]),
      .busy_o  (busy[g])
    );
  end

  pg_rs_latch i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire[CH_SET] && !err_q),
    .clr_i  (fire[CH_CLR]),
    .q_o    (pulse_o)
  );

  assign err_o = err_q;

  assert_rise_from_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(fire[CH_SET]));
  assert_fall_from_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $past(fire[CH_CLR]));
  assert_no_pulse_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$rose(pulse_o));
  assert_chans_together_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy[CH_SET]) |-> busy[CH_CLR]);
endmodule

// File: tb/test_dual_delay_pulse_gen.sv
module test_dual_delay_pulse_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       trig_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] set_code_i = '0;
  logic [7:0] clr_code_i = '0;
  logic       pulse_o;
  logic       err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_delay_pulse_gen i_dual_delay_pulse_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .load_i     (load_i),
    .set_code_i (set_code_i),
    .clr_code_i (clr_code_i),
    .pulse_o    (pulse_o),
    .err_o      (err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_codes(input int s, input int c);
    @(negedge clk_i);
    set_code_i = 8'(s);
    clr_code_i = 8'(c);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // one period; es/ec are the codes expected in force
  task automatic run_period(input int es, input int ec, input string req,
                            input bit mid, input int ms, input int mc);
    int rise = -1, fall = -1, nrise = 0, errbad = 0, n;
    bit prev, exp_err;
    exp_err = (ec <= es);
    n = ((es > ec) ? es : ec) + 6;
    @(negedge clk_i);
    prev = pulse_o;
    trig_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (k == 3) trig_i = 1'b0;
      if (mid && k == 1) begin
        set_code_i = 8'(ms); clr_code_i = 8'(mc); load_i = 1'b1;
      end
      if (mid && k == 2) load_i = 1'b0;
      if (pulse_o && !prev) begin nrise++; if (rise < 0) rise = k; end
      if (!pulse_o && prev && fall < 0) fall = k;
      prev = pulse_o;
      if (err_o != exp_err) errbad++;
    end
    chk(errbad == 0, {req, " R6 err_o"}, errbad, 0);
    if (exp_err) begin
      chk(nrise == 0, {req, " R6 no pulse"}, nrise, 0);
    end else begin
      chk(nrise == 1, {req, " R5 one pulse"}, nrise, 1);
      chk(rise == es + 2, {req, " R3 rise"}, rise, es + 2);
      chk(fall == ec + 2, {req, " R4 fall"}, fall, ec + 2);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0);
    chk(err_o == 1'b0, "R1 err", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pulse_o == 1'b0 && err_o == 1'b0, "R1 after release", int'({pulse_o, err_o}), 0);
  endtask

  task automatic t_basic;
    load_codes(3, 7);
    run_period(3, 7, "R2 held trigger", 1'b0, 0, 0);
  endtask

  task automatic t_edges;
    load_codes(0, 4);
    run_period(0, 4, "R9 zero set", 1'b0, 0, 0);
    load_codes(250, 255);
    run_period(250, 255, "R9 max", 1'b0, 0, 0);
  endtask

  task automatic t_bad;
    load_codes(5, 5);
    run_period(5, 5, "R6 equal", 1'b0, 0, 0);
    load_codes(6, 2);
    run_period(6, 2, "R6 inverted", 1'b0, 0, 0);
    load_codes(1, 3);
    run_period(1, 3, "R6 recover", 1'b0, 0, 0);
  endtask

  task automatic t_update;
    load_codes(2, 6);
    run_period(2, 6, "R7 mid load", 1'b1, 1, 9);
    run_period(1, 9, "R7 next period", 1'b0, 0, 0);
  endtask

  task automatic t_sequence;
    int s_tab[4] = '{4, 0, 7, 2};
    int c_tab[4] = '{5, 8, 12, 3};
    for (int i = 0; i < 4; i++) begin
      load_codes(s_tab[i], c_tab[i]);
      run_period(s_tab[i], c_tab[i], "R8 sequence", 1'b0, 0, 0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_edges();
        t_bad();
        t_update();
        t_sequence();
      end
      begin
        repeat (100000) @(posedge clk_i);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule